// File: doc/BRIEF.md
# Programmable CRC Engine

This block keeps a 16-bit running checksum over a byte stream. Each accepted byte folds into the checksum in a single clock through an unrolled eight-step XOR network, built as a linear feedback shift register. Two standard polynomials are built in, and each can run most-significant-bit first or reflected. A software-written polynomial can run in either bit order as well.

Bytes reach the engine from one of two sources, picked by a bit in the mode register. In the first, a DMA transfer path binds to the engine, and every beat strobe carries a byte. In the second, any bus master writes bytes to a data register. While the engine is bound to the DMA path, register data writes are dropped. While it is free, DMA beats are dropped.

Software writes the mode, the polynomial and the seed. An init command loads the seed into the shift register. The result can be read back at any time, and it also drives a dedicated output.

Top module: `crc_engine`

## Requirements
- R1: After reset the checksum output and the read-back values of mode, polynomial and seed are all zero.
- R2: Mode algorithm code 0 runs polynomial 0x8005, bits taken most significant first. From seed 0x0000 the bytes 0x31..0x39 give 0xFEE8.
- R3: Mode algorithm code 1 runs the reflected form of 0x8005 (0xA001), bits taken least significant first. From seed 0x0000 the bytes 0x31..0x39 give 0xBB3D.
- R4: Mode algorithm code 2 runs polynomial 0x1021, most significant bit first. From seed 0xFFFF the bytes 0x31..0x39 give 0x29B1.
- R5: Mode algorithm code 3 runs the reflected form of 0x1021 (0x8408). From seed 0xFFFF the bytes 0x31..0x39 give 0x6F91.
- R6: Algorithm code 6 runs the programmed polynomial most significant bit first. Code 7 runs its bit reverse least significant bit first.
- R7: A mode write with algorithm bit 2 clear loads the seed register with that algorithm's default: 0xFFFF if bit 1 is set, otherwise 0x0000. A mode write with bit 2 set leaves the seed unchanged.
- R8: A write to the command address loads the seed into the checksum at the next edge. This load wins over a byte accepted in the same cycle.
- R9: Each accepted byte updates the checksum at the clock edge that accepts it. The new value is on crc_o and at read address 3 right after that edge.
- R10: With mode bit 3 set (bound), every DMA beat is accepted and register writes to data address 4 are ignored.
- R11: With mode bit 3 clear (free), writes to address 4 feed their low byte and DMA beats are ignored.
- R12: Read addresses: 0 gives {bound, algorithm[2:0]} in bits 3:0, 1 the polynomial, 2 the seed, 3 the checksum, and any other address reads 0. Write addresses 0, 1 and 2 set mode, polynomial and seed.
- R13: In a cycle with no accepted byte and no init command, the checksum holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 3 | Register write address |
| cfg_wdata_i | input | 16 | Register write data |
| rd_addr_i | input | 3 | Read address |
| rd_data_o | output | 16 | Read data, combinational from rd_addr_i |
| dma_valid_i | input | 1 | DMA beat strobe |
| dma_data_i | input | 8 | DMA beat byte |
| crc_o | output | 16 | Current checksum |

## Verification
Every effect of a write or a beat appears right after the edge that takes it in: the checksum, the mode, the polynomial and the seed all lag their stimulus by exactly one edge. Read data follows the read address with no clock at all.

The bench drives each stimulus for one cycle at the falling edge. It deasserts the stimulus just after the next rising edge. It then advances its own bitwise model, then compares crc_o, and reads registers only while no write is pending. Dropped writes and beats are observed as an unchanged checksum in that same window.

// File: rtl/crc_eng_pkg.sv
package crc_eng_pkg;
  localparam int CRC_W  = 16;
  localparam int ALG_W  = 3;
  localparam int ADDR_W = 3;

  localparam logic [CRC_W-1:0] POLY_STD16 = 16'h8005;
  localparam logic [CRC_W-1:0] POLY_CCITT = 16'h1021;
  localparam logic [CRC_W-1:0] SEED_STD16 = 16'h0000;
  localparam logic [CRC_W-1:0] SEED_CCITT = 16'hFFFF;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_POLY = 3'd1;
  localparam logic [ADDR_W-1:0] A_SEED = 3'd2;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd4;

  typedef struct packed {
    logic             hw_src;
    logic [ALG_W-1:0] alg;
  } mode_t;

  localparam int MODE_W = $bits(mode_t);

  function automatic logic [CRC_W-1:0] bit_rev(input logic [CRC_W-1:0] v);
    logic [CRC_W-1:0] r;
    for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
    return r;
  endfunction
endpackage

// File: rtl/crc_eng_regs.sv
module crc_eng_regs
  import crc_eng_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CRC_W-1:0]  wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [CRC_W-1:0]  crc_i,
  output logic [CRC_W-1:0]  rd_data_o,
  output mode_t             mode_o,
  output logic [CRC_W-1:0]  poly_o,
  output logic [CRC_W-1:0]  seed_o,
  output logic              init_o,
  output logic              data_we_o
);
  mode_t            mode_q;
  logic [CRC_W-1:0] poly_q, seed_q;
  mode_t            mode_wr;

  assign mode_wr = mode_t'(wdata_i[MODE_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      poly_q <= '0;
      seed_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        A_MODE: begin
          mode_q <= mode_wr;
          // preset algorithms bring their own start value
          if (!mode_wr.alg[2]) seed_q <= mode_wr.alg[1] ? SEED_CCITT : SEED_STD16;
        end
        A_POLY:  poly_q <= wdata_i;
        A_SEED:  seed_q <= wdata_i;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (rd_addr_i)
      A_MODE:  rd_data_o = {{(CRC_W-MODE_W){1'b0}}, mode_q};
      A_POLY:  rd_data_o = poly_q;
      A_SEED:  rd_data_o = seed_q;
      A_CMD:   rd_data_o = crc_i;
      default: rd_data_o = '0;
    endcase
  end

  assign init_o    = we_i && (addr_i == A_CMD);
  assign data_we_o = we_i && (addr_i == A_DATA);
  assign mode_o    = mode_q;
  assign poly_o    = poly_q;
  assign seed_o    = seed_q;
endmodule

// File: rtl/crc_eng_poly_sel.sv
module crc_eng_poly_sel
  import crc_eng_pkg::*;
(
  input  logic [ALG_W-1:0] alg_i,
  input  logic [CRC_W-1:0] user_poly_i,
  output logic [CRC_W-1:0] poly_o,
  output logic             refl_o
);
  logic [CRC_W-1:0] fwd;

  // alg[2]: user polynomial, alg[1]: CCITT family, alg[0]: reflected order
  assign fwd    = alg_i[2] ? user_poly_i : (alg_i[1] ? POLY_CCITT : POLY_STD16);
  assign refl_o = alg_i[0];
  assign poly_o = refl_o ? bit_rev(fwd) : fwd;
endmodule

// File: rtl/crc_eng_step.sv
module crc_eng_step #(
  parameter int W  = 16,
  parameter int DW = 8
) (
  input  logic [W-1:0]  crc_i,
  input  logic [DW-1:0] data_i,
  input  logic [W-1:0]  poly_i,
  input  logic          refl_i,
  output logic [W-1:0]  crc_o
);
  logic [W-1:0] msb_c [DW+1];
  logic [W-1:0] lsb_c [DW+1];

  assign msb_c[0] = crc_i ^ {data_i, {(W-DW){1'b0}}};
  assign lsb_c[0] = crc_i ^ {{(W-DW){1'b0}}, data_i};

  for (genvar k = 0; k < DW; k++) begin : g_bit
    assign msb_c[k+1] = msb_c[k][W-1] ? ((msb_c[k] << 1) ^ poly_i) : (msb_c[k] << 1);
    assign lsb_c[k+1] = lsb_c[k][0]   ? ((lsb_c[k] >> 1) ^ poly_i) : (lsb_c[k] >> 1);
  end

  assign crc_o = refl_i ? lsb_c[DW] : msb_c[DW];
endmodule

// File: rtl/crc_engine.sv
module crc_engine
  import crc_eng_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [CRC_W-1:0]  cfg_wdata_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [CRC_W-1:0]  rd_data_o,
  input  logic              dma_valid_i,
  input  logic [DATA_W-1:0] dma_data_i,
  output logic [CRC_W-1:0]  crc_o
);
  mode_t             mode_q;
  logic [CRC_W-1:0]  poly_q, seed_q, poly_eff, crc_q, crc_next, crc_d;
  logic              refl, init, data_we, beat_ok;
  logic [DATA_W-1:0] beat_byte;

  crc_eng_regs u_regs (
    .clk_i, .rst_ni,
    .we_i(cfg_we_i), .addr_i(cfg_addr_i), .wdata_i(cfg_wdata_i),
    .rd_addr_i, .crc_i(crc_q), .rd_data_o,
    .mode_o(mode_q), .poly_o(poly_q), .seed_o(seed_q),
    .init_o(init), .data_we_o(data_we)
  );

  crc_eng_poly_sel u_psel (
    .alg_i(mode_q.alg), .user_poly_i(poly_q), .poly_o(poly_eff), .refl_o(refl)
  );

  // bound engine listens only to the DMA path
  assign beat_ok   = mode_q.hw_src ? dma_valid_i : data_we;
  assign beat_byte = mode_q.hw_src ? dma_data_i  : cfg_wdata_i[DATA_W-1:0];

  crc_eng_step #(.W(CRC_W), .DW(DATA_W)) u_step (
    .crc_i(crc_q), .data_i(beat_byte), .poly_i(poly_eff), .refl_i(refl), .crc_o(crc_next)
  );

  always_comb begin
    crc_d = crc_q;
    if (init)         crc_d = seed_q;
    else if (beat_ok) crc_d = crc_next;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) crc_q <= '0;
    else         crc_q <= crc_d;
  end

  assign crc_o = crc_q;
endmodule

// File: rtl/crc_engine_chk.sv
module crc_engine_chk
  import crc_eng_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [CRC_W-1:0]  wdata_i,
  input logic              dma_valid_i,
  input logic              bound_i,
  input logic [CRC_W-1:0]  seed_i,
  input logic [CRC_W-1:0]  crc_i
);
  logic cmd_wr, data_wr, mode_wr;
  assign cmd_wr  = we_i && (addr_i == A_CMD);
  assign data_wr = we_i && (addr_i == A_DATA);
  assign mode_wr = we_i && (addr_i == A_MODE);

  AST_INIT_LOADS_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr |=> crc_i == $past(seed_i)); // R8
  AST_RESULT_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmd_wr && !data_wr && !dma_valid_i) |=> $stable(crc_i)); // R13
  AST_BOUND_DROPS_REG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bound_i && data_wr && !dma_valid_i) |=> $stable(crc_i)); // R10
  AST_FREE_DROPS_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bound_i && dma_valid_i && !we_i) |=> $stable(crc_i)); // R11
  AST_PRESET_SEED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_wr && !wdata_i[2]) |=> seed_i == ($past(wdata_i[1]) ? SEED_CCITT : SEED_STD16)); // R7
endmodule

bind crc_engine crc_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .addr_i(cfg_addr_i),
  .wdata_i(cfg_wdata_i), .dma_valid_i(dma_valid_i), .bound_i(mode_q.hw_src),
  .seed_i(seed_q), .crc_i(crc_o)
);

// File: tb/crc_engine_bench.sv
`timescale 1ns/1ps
module crc_engine_bench;
  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_addr = 0, rd_addr = 0;
  logic [15:0] cfg_wdata = 0;
  logic [15:0] rd_data, crc;
  logic        dma_valid = 0;
  logic [7:0]  dma_data = 0;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  logic [2:0]  m_alg;
  logic        m_bind;
  logic [15:0] m_poly, m_seed, m_crc;

  always #2.5 clk = ~clk;

  crc_engine u_crc_engine (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .dma_valid_i(dma_valid), .dma_data_i(dma_data), .crc_o(crc)
  );

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  function automatic logic [15:0] fwd_poly();
    if (m_alg[2]) return m_poly;
    return m_alg[1] ? 16'h1021 : 16'h8005;
  endfunction

  // bit-serial reference
  function automatic logic [15:0] ref_byte(input logic [15:0] c, input logic [7:0] d,
                                           input logic [15:0] p, input logic r);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      if (r) begin
        fb = c[0] ^ d[i]; c = c >> 1; if (fb) c = c ^ rev16(p);
      end else begin
        fb = c[15] ^ d[7-i]; c = c << 1; if (fb) c = c ^ p;
      end
    end
    return c;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic we, input logic [2:0] a, input logic [15:0] wd,
                      input logic dv, input logic [7:0] dd);
    logic beat; logic [7:0] b;
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = wd; dma_valid = dv; dma_data = dd;
    @(posedge clk); #1;
    cfg_we = 0; dma_valid = 0;
    beat = m_bind ? dv : (we && a == 3'd4);
    b    = m_bind ? dd : wd[7:0];
    if (we && a == 3'd3) m_crc = m_seed;
    else if (beat) m_crc = ref_byte(m_crc, b, fwd_poly(), m_alg[0]);
    if (we) begin
      case (a)
        3'd0: begin
          m_alg = wd[2:0]; m_bind = wd[3];
          if (!wd[2]) m_seed = wd[1] ? 16'hFFFF : 16'h0000;
        end
        3'd1: m_poly = wd;
        3'd2: m_seed = wd;
        default: ;
      endcase
    end
  endtask

  task automatic rd(input logic [2:0] a, input string tag, input logic [15:0] exp);
    rd_addr = a; #0.5;
    check(tag, rd_data, exp);
  endtask

  task automatic feed_digits(input logic via_dma);
    for (int i = 0; i < 9; i++) begin
      if (via_dma) tick(0, 0, 0, 1, 8'h31 + 8'(i));
      else         tick(1, 3'd4, 16'h0031 + 16'(i), 0, 0);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_alg = 0; m_bind = 0; m_poly = 0; m_seed = 0; m_crc = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1 crc after reset", crc, 16'h0);
    rd(3'd0, "R1 mode reset", 16'h0);
    rd(3'd1, "R1 poly reset", 16'h0);
    rd(3'd2, "R1 seed reset", 16'h0);

    // R2
    tick(1, 0, 16'h0000, 0, 0); tick(1, 3, 0, 0, 0); feed_digits(0);
    check("R2 crc16 check value", crc, 16'hFEE8);
    // R3
    tick(1, 0, 16'h0001, 0, 0); tick(1, 3, 0, 0, 0); feed_digits(0);
    check("R3 crc16 reflected check value", crc, 16'hBB3D);
    // R4 with default seed
    tick(1, 0, 16'h0002, 0, 0);
    rd(3'd2, "R7 ccitt default seed", 16'hFFFF);
    tick(1, 3, 0, 0, 0); feed_digits(0);
    check("R4 ccitt check value", crc, 16'h29B1);
    // R5
    tick(1, 0, 16'h0003, 0, 0); tick(1, 3, 0, 0, 0); feed_digits(0);
    check("R5 ccitt reflected check value", crc, 16'h6F91);
    // R6 and R7: custom mode keeps the seed
    tick(1, 2, 16'h1234, 0, 0); tick(1, 1, 16'h8005, 0, 0); tick(1, 0, 16'h0006, 0, 0);
    rd(3'd2, "R7 custom mode keeps seed", 16'h1234);
    rd(3'd1, "R12 poly readback", 16'h8005);
    rd(3'd0, "R12 mode readback", 16'h0006);
    tick(1, 2, 16'h0000, 0, 0); tick(1, 3, 0, 0, 0); feed_digits(0);
    check("R6 custom msb-first", crc, 16'hFEE8);
    tick(1, 0, 16'h0007, 0, 0); tick(1, 3, 0, 0, 0); feed_digits(0);
    check("R6 custom reflected", crc, 16'hBB3D);
    // R10: bound, DMA feeds, register data ignored
    tick(1, 0, 16'h000A, 0, 0); tick(1, 3, 0, 0, 0);
    check("R8 init loads seed", crc, 16'hFFFF);
    tick(1, 3'd4, 16'h0055, 0, 0);
    check("R10 bound ignores data write", crc, 16'hFFFF);
    feed_digits(1);
    check("R10 dma ccitt check value", crc, 16'h29B1);
    rd(3'd3, "R12 result readback", 16'h29B1);
    // R8: init beats a same-cycle DMA beat
    tick(1, 3, 0, 1, 8'hA5);
    check("R8 init wins over beat", crc, 16'hFFFF);
    // R11: free, DMA ignored
    tick(1, 0, 16'h0002, 0, 0);
    tick(0, 0, 0, 1, 8'h3C);
    check("R11 free ignores dma", crc, 16'hFFFF);
    tick(0, 0, 0, 0, 0);
    check("R13 idle holds", crc, 16'hFFFF);
    rd(3'd6, "R12 unmapped reads zero", 16'h0);

    // random mix
    for (int it = 0; it < 4000; it++) begin
      int k;
      logic we, dv; logic [2:0] a; logic [15:0] wd;
      k = $urandom_range(0, 99);
      dv = ($urandom_range(0, 1) == 1);
      we = 1; wd = 16'($urandom);
      if (k < 40)      a = 3'd4;
      else if (k < 45) a = 3'd3;
      else if (k < 50) begin a = 3'd0; wd = {12'h0, wd[3:0]}; end
      else if (k < 53) a = 3'd1;
      else if (k < 56) a = 3'd2;
      else begin a = 3'd0; we = 0; end
      tick(we, a, wd, dv, 8'($urandom));
      check("R9 random byte update", crc, m_crc);
      if (it % 50 == 0) begin
        rd(3'd3, "R12 random result read", m_crc);
        rd(3'd2, "R7 random seed read", m_seed);
      end
    end
    finish_run();
  end

  initial void'($urandom(32'd1729));
endmodule